// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Overflow Flag

This block is a purely combinational arithmetic-logic unit for the execute stage of a simple processor. It takes two operands of parameterised width and a three-bit operation code. It returns one result word, a carry-out bit and an overflow bit. The overflow bit is intended for the processor's exception logic. The block has no clock, no reset and no state: every output follows its inputs within the same evaluation.

A single ripple-carry adder serves signed add, unsigned add, unsigned subtract and the signed less-than comparison. Subtraction is done by feeding the bitwise complement of B into the adder with a carry-in of one. How overflow is judged depends on the operation. An unsigned operation reports the adder's carry out of the top bit. A signed add reports a disagreement between the operand signs and the result sign.

Top module: `arith_logic_unit`

## Requirements
- R1: Operation code 3'b000 gives the bitwise AND of A and B, with carry-out and overflow both 0.
- R2: Operation code 3'b001 gives the bitwise OR of A and B, with carry-out and overflow both 0.
- R3: Operation code 3'b101 gives the bitwise complement of A (B is ignored), with carry-out and overflow both 0.
- R4: Operation code 3'b010 (signed add) gives (A + B) mod 2^N. Carry-out is bit N of the full unsigned sum.
- R5: For 3'b010, overflow is 1 exactly when A and B have equal sign bits (bit N-1) and the result's sign bit differs from them.
- R6: Operation code 3'b110 (unsigned add) gives (A + B) mod 2^N. Carry-out is bit N of the sum, and overflow equals that carry-out.
- R7: Operation code 3'b111 (unsigned subtract) gives (A - B) mod 2^N, formed as A + ~B + 1. Carry-out is the adder's top carry, which is 1 exactly when A >= B as unsigned values. Overflow equals that carry-out.
- R8: Operation code 3'b100 compares A and B as two's-complement values. The result is 1 in bit 0 and 0 elsewhere when A < B, and all zeros otherwise. Carry-out and overflow are 0.
- R9: Operation code 3'b011 is reserved. It drives a zero result, carry-out 0 and overflow 0.
- R10: A signed add of one non-negative and one negative operand never raises overflow.
- R11: Outputs follow any change on the inputs without a clock edge. The block holds no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Operation code |
| a_i | input | N | Operand A |
| b_i | input | N | Operand B |
| result_o | output | N | Selected result word |
| carry_o | output | 1 | Adder carry out of bit N-1 for add and subtract codes, else 0 |
| overflow_o | output | 1 | Overflow flag for the exception logic |

## Verification
The checker evaluates several properties on every input change. It confirms that the logic codes and the reserved code keep both flags low, and that the reserved code gives a zero result. It confirms that the comparison result uses only bit 0. It checks that unsigned overflow tracks the carry, that the signed overflow rule holds against the result port, and that a mixed-sign signed add never flags overflow. The bench's scenarios are needed to show that the arithmetic values are correct. These cover wrap-around at the extremes, a full-length carry ripple, subtracting equal operands, and a signed comparison whose internal difference overflows. The scenarios also show that outputs update between clock edges with no clock involved.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    OP_AND  = 3'b000,
    OP_OR   = 3'b001,
    OP_ADDS = 3'b010,
    OP_RSVD = 3'b011,
    OP_SLT  = 3'b100,
    OP_NOTA = 3'b101,
    OP_ADDU = 3'b110,
    OP_SUBU = 3'b111
  } alu_op_e;

  // One-bit full adder, sum output
  function automatic logic fa_sum(input logic x, input logic y, input logic ci);
    return x ^ y ^ ci;
  endfunction

  // One-bit full adder, carry output
  function automatic logic fa_carry(input logic x, input logic y, input logic ci);
    return (x & y) | (x & ci) | (y & ci);
  endfunction

  // Codes whose adder path runs with B complemented and carry-in set
  function automatic logic needs_negate(input alu_op_e op);
    return (op == OP_SUBU) || (op == OP_SLT);
  endfunction

  // Codes that expose the adder carry on the carry output
  function automatic logic uses_carry(input alu_op_e op);
    return (op == OP_ADDS) || (op == OP_ADDU) || (op == OP_SUBU);
  endfunction

  // Sign-mismatch rule: both inputs share a sign that the sum does not
  function automatic logic sign_mismatch(input logic xs, input logic ys, input logic ss);
    return (xs & ys & ~ss) | (~xs & ~ys & ss);
  endfunction

endpackage

// File: rtl/alu_full_adder.sv
module alu_full_adder
  import alu_pkg::*;
(
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  assign s_o = fa_sum(x_i, y_i, c_i);
  assign c_o = fa_carry(x_i, y_i, c_i);
endmodule

// File: rtl/alu_ripple_adder.sv
module alu_ripple_adder #(
  parameter int N = 32
) (
  input  logic [N-1:0] x_i,
  input  logic [N-1:0] y_i,
  input  logic         cin_i,
  output logic [N-1:0] sum_o,
  output logic         cout_o
);
  logic [N:0] chain;

  assign chain[0] = cin_i;

  for (genvar k = 0; k < N; k++) begin : g_bit
    alu_full_adder u_fa (
      .x_i (x_i[k]),
      .y_i (y_i[k]),
      .c_i (chain[k]),
      .s_o (sum_o[k]),
      .c_o (chain[k+1])
    );
  end

  assign cout_o = chain[N];
endmodule

// File: rtl/alu_bitwise_unit.sv
module alu_bitwise_unit #(
  parameter int N = 32
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic [N-1:0] and_o,
  output logic [N-1:0] or_o,
  output logic [N-1:0] inv_o
);
  assign and_o = a_i & b_i;
  assign or_o  = a_i | b_i;
  assign inv_o = ~a_i;
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_pkg::*;
(
  input  alu_op_e op_i,
  input  logic    a_msb_i,
  input  logic    y_msb_i,
  input  logic    s_msb_i,
  input  logic    carry_i,
  output logic    slt_o,
  output logic    carry_o,
  output logic    ovf_o
);
  logic diff_ovf;

  // Signed overflow of the adder path, with y as the adder's second input
  assign diff_ovf = sign_mismatch(a_msb_i, y_msb_i, s_msb_i);

  // A < B as signed: sign of A - B, corrected when that difference overflowed
  assign slt_o = s_msb_i ^ diff_ovf;

  assign carry_o = uses_carry(op_i) ? carry_i : 1'b0;

  always_comb begin
    unique case (op_i)
      OP_ADDS:          ovf_o = diff_ovf;
      OP_ADDU, OP_SUBU: ovf_o = carry_i;
      default:          ovf_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/arith_logic_unit.sv
module arith_logic_unit
  import alu_pkg::*;
#(
  parameter int N = 32
) (
  input  logic [2:0]   op_i,
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic [N-1:0] result_o,
  output logic         carry_o,
  output logic         overflow_o
);
  localparam int MSB = N - 1;

  alu_op_e     op_w;
  logic        neg_w;
  logic [N-1:0] y_w;
  logic [N-1:0] sum_w;
  logic        add_carry_w;
  logic [N-1:0] and_w, or_w, inv_w;
  logic        slt_w;

  assign op_w  = alu_op_e'(op_i);
  assign neg_w = needs_negate(op_w);
  assign y_w   = b_i ^ {N{neg_w}};

  alu_ripple_adder #(.N(N)) u_adder (
    .x_i    (a_i),
    .y_i    (y_w),
    .cin_i  (neg_w),
    .sum_o  (sum_w),
    .cout_o (add_carry_w)
  );

  alu_bitwise_unit #(.N(N)) u_bitwise (
    .a_i   (a_i),
    .b_i   (b_i),
    .and_o (and_w),
    .or_o  (or_w),
    .inv_o (inv_w)
  );

  alu_flag_unit u_flags (
    .op_i    (op_w),
    .a_msb_i (a_i[MSB]),
    .y_msb_i (y_w[MSB]),
    .s_msb_i (sum_w[MSB]),
    .carry_i (add_carry_w),
    .slt_o   (slt_w),
    .carry_o (carry_o),
    .ovf_o   (overflow_o)
  );

  // Opcode decoder: steer one unit onto the result
  always_comb begin
    unique case (op_w)
      OP_AND:                    result_o = and_w;
      OP_OR:                     result_o = or_w;
      OP_NOTA:                   result_o = inv_w;
      OP_ADDS, OP_ADDU, OP_SUBU: result_o = sum_w;
      OP_SLT:                    result_o = {{(N-1){1'b0}}, slt_w};
      default:                   result_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_checks.sv
module alu_checks #(
  parameter int N = 32
) (
  input logic [2:0]   op,
  input logic [N-1:0] a,
  input logic [N-1:0] b,
  input logic [N-1:0] res,
  input logic         cy,
  input logic         ov,
  input logic [N-1:0] sum,
  input logic         add_cy
);
  always_comb begin
    // R1 R2 R3: bitwise codes keep both flags low
    if (op == 3'b000 || op == 3'b001 || op == 3'b101)
      a_r3_logic_flags_low: assert (!cy && !ov);

    // R9: reserved code drives nothing
    if (op == 3'b011)
      a_r9_reserved_quiet: assert (res == '0 && !cy && !ov);

    // R8: comparison uses bit 0 only and never flags overflow
    if (op == 3'b100)
      a_r8_slt_shape: assert (res[N-1:1] == '0 && !ov && !cy);

    // R6 R7: unsigned overflow tracks the carry port
    if (op == 3'b110 || op == 3'b111)
      a_r6_unsigned_ovf_is_carry: assert (ov == cy);

    // R5: signed overflow against the result port signs
    if (op == 3'b010)
      a_r5_signed_ovf: assert (ov == ((a[N-1] == b[N-1]) && (res[N-1] != a[N-1])));

    // R10: mixed signs never overflow on a signed add
    if (op == 3'b010 && (a[N-1] != b[N-1]))
      a_r10_mixed_sign_no_ovf: assert (!ov);

    // R4: adder path delivers the full-width sum and carry for signed add
    if (op == 3'b010)
      a_r4_sum_and_carry: assert ({add_cy, sum} == ({1'b0, a} + {1'b0, b}) && res == sum);
  end
endmodule

bind arith_logic_unit alu_checks #(.N(N)) u_alu_checks (
  .op     (op_i),
  .a      (a_i),
  .b      (b_i),
  .res    (result_o),
  .cy     (carry_o),
  .ov     (overflow_o),
  .sum    (sum_w),
  .add_cy (add_carry_w)
);

// File: tb/tb_arith_logic_unit.sv
module tb_arith_logic_unit;
  localparam int N = 32;

  typedef struct packed {
    logic [2:0]   op;
    logic [N-1:0] a;
    logic [N-1:0] b;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{3'b000, 32'hFF00FF00, 32'h0F0F0F0F},
    '{3'b001, 32'h12340000, 32'h00005678},
    '{3'b010, 32'h7FFFFFFF, 32'h00000001},
    '{3'b010, 32'h80000000, 32'h80000000},
    '{3'b010, 32'h00000005, 32'hFFFFFFFD},
    '{3'b011, 32'hDEADBEEF, 32'hCAFEF00D},
    '{3'b100, 32'hFFFFFFFF, 32'h00000001},
    '{3'b100, 32'h00000001, 32'hFFFFFFFF},
    '{3'b100, 32'h80000000, 32'h7FFFFFFF},
    '{3'b101, 32'hA5A5A5A5, 32'h12345678},
    '{3'b110, 32'hFFFFFFFF, 32'h00000001},
    '{3'b110, 32'h00000001, 32'h00000002},
    '{3'b111, 32'h00000005, 32'h00000003},
    '{3'b111, 32'h00000003, 32'h00000005},
    '{3'b111, 32'h1234ABCD, 32'h1234ABCD},
    '{3'b100, 32'h00000042, 32'h00000042}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0]   op;
  logic [N-1:0] a, b;
  logic [N-1:0] result;
  logic         carry, ovf;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  arith_logic_unit #(.N(N)) dut (
    .op_i       (op),
    .a_i        (a),
    .b_i        (b),
    .result_o   (result),
    .carry_o    (carry),
    .overflow_o (ovf)
  );

  function automatic string tag_of(input logic [2:0] o);
    case (o)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R4/R5";
      3'b011: return "R9";
      3'b100: return "R8";
      3'b101: return "R3";
      3'b110: return "R6";
      default: return "R7";
    endcase
  endfunction

  // Reference model written from the requirements
  task automatic model(input logic [2:0] o, input logic [N-1:0] x, input logic [N-1:0] y,
                       output logic [N-1:0] r, output logic c, output logic v);
    longint sx, sy, ss;
    logic [N:0] wide;
    r = '0; c = 1'b0; v = 1'b0;
    case (o)
      3'b000: r = x & y;
      3'b001: r = x | y;
      3'b101: r = ~x;
      3'b010: begin
        wide = {1'b0, x} + {1'b0, y};
        r = wide[N-1:0]; c = wide[N];
        sx = longint'($signed(x)); sy = longint'($signed(y)); ss = sx + sy;
        v = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
      end
      3'b110: begin
        wide = {1'b0, x} + {1'b0, y};
        r = wide[N-1:0]; c = wide[N]; v = c;
      end
      3'b111: begin
        r = x - y; c = (x >= y); v = c;
      end
      3'b100: r = ($signed(x) < $signed(y)) ? 1 : 0;
      default: r = '0;
    endcase
  endtask

  task automatic check(input string tag, input logic [N-1:0] er, input logic ec, input logic ev);
    n_checks++;
    if (result !== er || carry !== ec || ovf !== ev) begin
      n_fail++;
      $display("FAIL %s op=%b a=%h b=%h : got r=%h c=%b v=%b, expected r=%h c=%b v=%b",
               tag, op, a, b, result, carry, ovf, er, ec, ev);
    end
  endtask

  task automatic apply_and_check(input string tag, input logic [2:0] o,
                                 input logic [N-1:0] x, input logic [N-1:0] y);
    logic [N-1:0] er; logic ec, ev;
    @(negedge clk);
    op = o; a = x; b = y;
    #1;
    model(o, x, y, er, ec, ev);
    check(tag, er, ec, ev);
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    op = 3'b000; a = '0; b = '0;
    repeat (3) @(posedge clk);
    #1;
    // Reset state: all-zero inputs under AND give all-zero outputs (R1)
    check("R1 reset-state", '0, 1'b0, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++)
      apply_and_check(tag_of(VECS[i].op), VECS[i].op, VECS[i].a, VECS[i].b);

    // R4/R6: full-length carry ripple
    apply_and_check("R6 ripple", 3'b110, 32'h7FFFFFFF, 32'h00000001);
    apply_and_check("R4 ripple", 3'b010, 32'hFFFFFFFF, 32'h00000001);

    // R5: negative + negative without overflow
    apply_and_check("R5 neg-neg ok", 3'b010, 32'hFFFFFFFF, 32'hFFFFFFFF);
    // R5: positive + positive overflow
    apply_and_check("R5 pos-pos ovf", 3'b010, 32'h40000000, 32'h40000000);

    // R10: mixed signs at extremes never overflow
    apply_and_check("R10 mix extreme", 3'b010, 32'h7FFFFFFF, 32'h80000000);
    for (int k = 0; k < 8; k++)
      apply_and_check("R10 mix sweep", 3'b010, 32'h7FFFFFFF >> k, 32'h80000000 | (32'h1 << k));

    // R7: zero minus one wraps and clears carry
    apply_and_check("R7 0-1", 3'b111, 32'h00000000, 32'h00000001);

    // R8: extremes of signed compare
    apply_and_check("R8 max<min", 3'b100, 32'h7FFFFFFF, 32'h80000000);

    // R3: B ignored under NOT A
    apply_and_check("R3 b-ignored", 3'b101, 32'h0000FFFF, 32'hFFFFFFFF);
    apply_and_check("R3 b-ignored", 3'b101, 32'h0000FFFF, 32'h00000000);

    // R9: reserved with all-ones operands
    apply_and_check("R9 ones", 3'b011, 32'hFFFFFFFF, 32'hFFFFFFFF);

    // R11: outputs follow an input change with no clock edge in between
    @(posedge clk);
    #0.5;
    op = 3'b110; a = 32'h00000010; b = 32'h00000020;
    #0.5;
    check("R11 mid-cycle", 32'h00000030, 1'b0, 1'b0);
    a = 32'hFFFFFFF0;
    #0.5;
    check("R11 mid-cycle", 32'h00000010, 1'b1, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule